// File: doc/BRIEF.md
# Extended-precision zero-compare flag unit

This block takes one 80-bit extended-precision floating-point value, the current top-of-stack operand, and compares it against zero. The result goes into the three condition-code bits of a floating-point status word, C3, C2 and C0, and C1 is cleared. The block also raises sticky flags for an invalid operation, a stack fault and a denormal operand.

The operand has an explicit integer bit. Encodings that the format does not support, and NaNs, compare as unordered. The sign of a zero has no effect on the result. A separate tag input says whether the stack slot is empty, and an empty slot is reported as a stack underflow.

A one-cycle start strobe launches a compare. One clock later the condition codes are registered, the new exception flags are ORed into the held sticky flags, and a one-cycle done pulse is given. The sticky flags are cleared only by their own clear input.

Top module: `ext_zero_cmp`

## Requirements
- R1: The operand layout is sign at bit 79, biased exponent at bits 78:64, and explicit integer bit at bit 63 with the fraction at bits 62:0. A positive normal or positive denormal operand gives {C3,C2,C0} = 000.
- R2: A negative normal or negative denormal operand gives {C3,C2,C0} = 001.
- R3: An operand with exponent 0 and significand 0 gives {C3,C2,C0} = 100 for either sign, with no exception flag.
- R4: C1 is 0 after every completed compare.
- R5: Three kinds of operand give {C3,C2,C0} = 111 and set the invalid flag. The first is any NaN: exponent all ones, integer bit set, fraction nonzero. The second is an all-ones exponent with the integer bit clear. The third is a nonzero exponent below all ones with the integer bit clear.
- R6: An operand with exponent 0 and a nonzero significand sets the denormal flag and is compared by its sign. This includes the case with the integer bit set.
- R7: When the slot-empty input is high, the result is {C3,C2,C0} = 111 and both the stack-fault and invalid flags are set, whatever the operand is.
- R8: An infinity (exponent all ones, significand 0x8000000000000000) gives 000 when positive and 001 when negative, and raises no flag.
- R9: The exception flags are sticky. They are ORed with each new result and cleared only by the clear input. When the clear and start inputs are high in the same cycle, the flags afterwards hold only the new compare's flags.
- R10: Results appear on the first clock edge after the start strobe, together with a done pulse one cycle wide. The condition codes keep their value when no compare completes.
- R11: After reset all condition codes, flags and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a compare |
| operand_i | input | 80 | Top-of-stack value |
| slot_empty_i | input | 1 | Stack slot is tagged empty |
| clr_flags_i | input | 1 | Clears the sticky exception flags |
| c0_o | output | 1 | Condition code C0 |
| c1_o | output | 1 | Condition code C1 |
| c2_o | output | 1 | Condition code C2 |
| c3_o | output | 1 | Condition code C3 |
| invalid_o | output | 1 | Sticky invalid-operation flag |
| stack_fault_o | output | 1 | Sticky stack-fault flag |
| denormal_o | output | 1 | Sticky denormal-operand flag |
| done_o | output | 1 | Compare completed this cycle |

## Verification
A flag clear and a compare that raises new flags can land on the same clock edge. In that case the clear must remove the old held flags and keep the new ones. The bench first leaves invalid and stack-fault set from an empty-slot compare. It then raises clear and start together with a denormal operand, and expects only the denormal flag to remain. A second case raises clear and start together with a NaN and checks that invalid survives the clear.

// File: rtl/ezc_pkg.sv
package ezc_pkg;
  parameter int EXP_W = 15;
  parameter int SIG_W = 64;
  localparam int OP_W = 1 + EXP_W + SIG_W;
  localparam int FLAG_N = 3;

  typedef struct packed {
    logic c3;
    logic c2;
    logic c0;
  } cc_t;

  // flag vector order: {invalid, stack_fault, denormal}
  typedef struct packed {
    cc_t               cc;
    logic [FLAG_N-1:0] flags;
  } cmp_res_t;
endpackage

// File: rtl/ezc_classify.sv
module ezc_classify
  import ezc_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int SW = SIG_W
) (
  input  logic [EW+SW:0] operand_i,
  input  logic           empty_i,
  output cmp_res_t       res_o
);
  localparam logic [EW-1:0] EXP_MAX = {EW{1'b1}};

  logic          sgn;
  logic [EW-1:0] exp_f;
  logic          int_bit;
  logic [SW-2:0] frac;
  logic          exp_zero, exp_ones, sig_zero, frac_zero;

  assign sgn       = operand_i[EW+SW];
  assign exp_f     = operand_i[EW+SW-1:SW];
  assign int_bit   = operand_i[SW-1];
  assign frac      = operand_i[SW-2:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = (exp_f == EXP_MAX);
  assign frac_zero = (frac == '0);
  assign sig_zero  = frac_zero && !int_bit;

  always_comb begin
    res_o = '0;
    if (empty_i) begin
      res_o.cc    = '{c3: 1'b1, c2: 1'b1, c0: 1'b1};
      res_o.flags = 3'b110;
    end else if (exp_zero) begin
      if (sig_zero) begin
        res_o.cc.c3 = 1'b1;
      end else begin
        res_o.cc.c0 = sgn;
        res_o.flags = 3'b001;
      end
    end else if (!int_bit || (exp_ones && !frac_zero)) begin
      // unnormal, pseudo-inf/NaN, or real NaN
      res_o.cc    = '{c3: 1'b1, c2: 1'b1, c0: 1'b1};
      res_o.flags = 3'b100;
    end else begin
      res_o.cc.c0 = sgn;
    end
  end
endmodule

// File: rtl/ezc_sticky.sv
module ezc_sticky #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[g] <= 1'b0;
      else         q_o[g] <= (q_o[g] && !clr_i) || (set_en_i && set_i[g]);
    end
  end
endmodule

// File: rtl/ext_zero_cmp.sv
module ext_zero_cmp
  import ezc_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int SW = SIG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [EW+SW:0] operand_i,
  input  logic         slot_empty_i,
  input  logic         clr_flags_i,
  output logic         c0_o,
  output logic         c1_o,
  output logic         c2_o,
  output logic         c3_o,
  output logic         invalid_o,
  output logic         stack_fault_o,
  output logic         denormal_o,
  output logic         done_o
);
  cmp_res_t          res;
  cc_t               cc_q;
  logic [FLAG_N-1:0] flags_q;

  ezc_classify #(.EW(EW), .SW(SW)) u_classify (
    .operand_i (operand_i),
    .empty_i   (slot_empty_i),
    .res_o     (res)
  );

  ezc_sticky #(.N(FLAG_N)) u_sticky (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (start_i),
    .set_i    (res.flags),
    .clr_i    (clr_flags_i),
    .q_o      (flags_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) cc_q <= res.cc;
    end
  end

  assign c0_o          = cc_q.c0;
  assign c2_o          = cc_q.c2;
  assign c3_o          = cc_q.c3;
  assign c1_o          = 1'b0;
  assign invalid_o     = flags_q[2];
  assign stack_fault_o = flags_q[1];
  assign denormal_o    = flags_q[0];
endmodule

// File: rtl/ext_zero_cmp_chk.sv
module ext_zero_cmp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic clr_flags_i,
  input logic c0_o,
  input logic c1_o,
  input logic c2_o,
  input logic c3_o,
  input logic invalid_o,
  input logic stack_fault_o,
  input logic denormal_o,
  input logic done_o
);
  // R10
  done_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  // R10
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  // R10
  cc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable({c3_o, c2_o, c0_o}));
  // R4
  c1_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !c1_o);
  // R5
  unordered_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c2_o |-> (c3_o && c0_o));
  // R7
  stack_implies_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_fault_o |-> invalid_o);
  // R9
  inv_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_o && !clr_flags_i) |=> invalid_o);
  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_flags_i && !start_i) |=> !(invalid_o || stack_fault_o || denormal_o));
endmodule

bind ext_zero_cmp ext_zero_cmp_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .clr_flags_i   (clr_flags_i),
  .c0_o          (c0_o),
  .c1_o          (c1_o),
  .c2_o          (c2_o),
  .c3_o          (c3_o),
  .invalid_o     (invalid_o),
  .stack_fault_o (stack_fault_o),
  .denormal_o    (denormal_o),
  .done_o        (done_o)
);

// File: tb/ext_zero_cmp_bench.sv
module ext_zero_cmp_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [79:0] operand_i = '0;
  logic        slot_empty_i = 1'b0;
  logic        clr_flags_i = 1'b0;
  logic c0_o, c1_o, c2_o, c3_o, invalid_o, stack_fault_o, denormal_o, done_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;

  ext_zero_cmp u_ext_zero_cmp (.*);

  // entry: {empty, operand, exp {c3,c2,c0}, exp {inv,stk,den}}
  localparam int NV = 20;
  localparam logic [86:0] VEC [NV] = '{
    {1'b0, 80'h3FFF8000000000000000, 3'b000, 3'b000}, // R1 +normal
    {1'b0, 80'hBFFF8000000000000000, 3'b001, 3'b000}, // R2 -normal
    {1'b0, 80'h00000000000000000000, 3'b100, 3'b000}, // R3 +0
    {1'b0, 80'h80000000000000000000, 3'b100, 3'b000}, // R3 -0
    {1'b0, 80'h00000000000000000001, 3'b000, 3'b001}, // R6 +denorm
    {1'b0, 80'h80000000000000000001, 3'b001, 3'b001}, // R6 -denorm
    {1'b0, 80'h00008000000000000000, 3'b000, 3'b001}, // R6 +pseudo-denorm
    {1'b0, 80'h80008000000000000000, 3'b001, 3'b001}, // R6 -pseudo-denorm
    {1'b0, 80'h7FFF8000000000000000, 3'b000, 3'b000}, // R8 +inf
    {1'b0, 80'hFFFF8000000000000000, 3'b001, 3'b000}, // R8 -inf
    {1'b0, 80'h7FFFC000000000000000, 3'b111, 3'b100}, // R5 +qnan
    {1'b0, 80'hFFFF8000000000000001, 3'b111, 3'b100}, // R5 -snan
    {1'b0, 80'h7FFF0000000000000000, 3'b111, 3'b100}, // R5 +pseudo-inf
    {1'b0, 80'hFFFF0000000000000000, 3'b111, 3'b100}, // R5 -pseudo-inf
    {1'b0, 80'h7FFF0000000000000001, 3'b111, 3'b100}, // R5 pseudo-nan
    {1'b0, 80'h3FFF4000000000000000, 3'b111, 3'b100}, // R5 +unnormal
    {1'b0, 80'hBFFF0000000000000000, 3'b111, 3'b100}, // R5 -unnormal
    {1'b0, 80'h7FFE8000000000000000, 3'b000, 3'b000}, // R1 max normal
    {1'b1, 80'h3FFF8000000000000000, 3'b111, 3'b110}, // R7 empty
    {1'b1, 80'h80000000000000000001, 3'b111, 3'b110}  // R7 empty, denorm ignored
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // returns {c3,c2,c0,c1,inv,stk,den,done}
  function automatic logic [7:0] outs();
    return {c3_o, c2_o, c0_o, c1_o, invalid_o, stack_fault_o, denormal_o, done_o};
  endfunction

  // drive at negedge; result visible one edge later
  task automatic do_op(logic emp, logic [79:0] op, logic clr);
    @(negedge clk_i);
    start_i = 1'b1; operand_i = op; slot_empty_i = emp; clr_flags_i = clr;
    @(negedge clk_i);
    start_i = 1'b0; clr_flags_i = 1'b0; slot_empty_i = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk_i);
    clr_flags_i = 1'b1;
    @(negedge clk_i);
    clr_flags_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R11 reset", outs(), 8'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_clear();
      do_op(VEC[i][86], VEC[i][85:6], 1'b0);
      check($sformatf("R1-vector %0d (R2 R3 R5 R6 R7 R8 R4)", i), outs(),
            {VEC[i][5:3], 1'b0, VEC[i][2:0], 1'b1});
    end

    // R10 done one cycle wide, codes held
    do_clear();
    do_op(1'b0, 80'hBFFF8000000000000000, 1'b0);
    @(negedge clk_i);
    check("R10 done drop/hold", outs(), 8'b001_0_000_0);

    // R9 sticky across later clean compare
    do_op(1'b1, 80'h0, 1'b0);
    do_op(1'b0, 80'h3FFF8000000000000000, 1'b0);
    check("R9 sticky", outs(), 8'b000_0_110_1);

    // R9 clear + start same cycle: only new flags
    do_op(1'b0, 80'h00000000000000000001, 1'b1);
    check("R9 clr+start denorm", outs(), 8'b000_0_001_1);
    do_op(1'b0, 80'h7FFFC000000000000000, 1'b1);
    check("R9 clr+start nan", outs(), 8'b111_0_100_1);

    // R9 clear alone
    do_clear();
    check("R9 clear", outs(), 8'b111_0_000_0);

    // R11 reset mid-run
    do_op(1'b1, 80'h0, 1'b0);
    rst_ni = 1'b0;
    #2;
    check("R11 async reset", outs(), 8'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule